// File: doc/BRIEF.md
# Shared Byte FIFO with Status Byte

This block is a single byte-wide FIFO of 4096 entries that serves both the transmit and the receive path. Only one direction fills it at a time. Bytes go in through a push port, which carries a flag that says whether the byte is headed for transmit or was received. Bytes come out through a pop port, and the popped byte appears on a registered output one cycle later. The FIFO only moves data while the FIFO-enable bit (0x02) of the mode byte input is set. With that bit clear, the storage, the count and the flags are all frozen.

The block reports its state in two ways: an eight-bit status byte, and a fill count split into a low byte and a high byte. The status byte is read-only except for one write-only clear bit, which is reached through a small register write port (address 5, bit value 0x08). Writing that bit empties the FIFO and drops the sticky overflow and underflow flags. Three further status bits carry end-of-frame, receive-error and transmit-error indications, which come from the surrounding line logic.

Top module: `fifo_stat_top`

## Requirements
- R1: After reset the count bytes are 0, pop_data is 0 and the status byte is 0x04 (only the empty bit set) while the three event inputs are low.
- R2: Accepted bytes leave in the order they were pushed, and the popped byte is on pop_data in the cycle after the pop.
- R3: While mode bit 0x02 is clear, push and pop change neither the count, nor the stored bytes, nor pop_data, nor any status flag.
- R4: The fill count is shown as count_lo = count[7:0] and count_hi = count[15:8]. It never exceeds 4096, so a full FIFO reads count_hi 0x10 and count_lo 0x00.
- R5: A push into a full FIFO, with no pop in the same cycle, is dropped and sets status bit 0x20 (overflow). That bit stays set until it is cleared.
- R6: A pop from an empty FIFO puts 0 on pop_data and sets status bit 0x40 (underflow). That bit stays set until it is cleared.
- R7: Status bit 0x10 is 1 after an accepted push with push_tx=1 and 0 after an accepted push with push_tx=0. It resets to 0.
- R8: A register write to address 5 with data bit 0x08 set empties the FIFO and clears bits 0x20 and 0x40 by the next cycle. A push or pop in that same cycle is ignored. Writes to any other address, or without bit 0x08, change nothing.
- R9: Status bit 0x08 always reads 0.
- R10: Status bit 0x04 is 1 exactly when the count is 0.
- R11: Status bits 0x80, 0x02 and 0x01 follow the inputs frame_end, rx_err and tx_err in the same cycle.
- R12: A simultaneous push and pop on a full FIFO is accepted and leaves the count unchanged. On an empty FIFO, the push is accepted and the pop underflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_bits | input | 8 | Mode byte; bit 0x02 enables the FIFO |
| push | input | 1 | Push request |
| push_tx | input | 1 | Pushed byte belongs to transmit (1) or receive (0) |
| push_data | input | 8 | Byte to push |
| pop | input | 1 | Pop request |
| pop_data | output | 8 | Byte from the last pop, registered |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register write address |
| reg_wdata | input | 8 | Register write data |
| frame_end | input | 1 | End-of-frame indication |
| rx_err | input | 1 | Receive error indication |
| tx_err | input | 1 | Transmit error indication |
| status | output | 8 | Status byte |
| count_lo | output | 8 | Fill count, low byte |
| count_hi | output | 8 | Fill count, high byte |

## Verification
Every result that depends on state lands one edge after its stimulus. This covers pop_data, the count bytes, the empty bit, the sticky flags, the direction bit and the effect of a clear. The event bits are the exception: they follow their inputs in the same cycle. The bench changes inputs on the falling edge, lets exactly one rising edge pass, and reads the outputs at the next falling edge. It compares them there against a queue model kept in the bench. The event bits are read in the same half-cycle they are driven, before any edge.

// File: rtl/fifo_stat_pkg.sv
package fifo_stat_pkg;
   // status byte bit positions
   localparam int unsigned ST_EOF   = 7;
   localparam int unsigned ST_UNDER = 6;
   localparam int unsigned ST_OVER  = 5;
   localparam int unsigned ST_DIR   = 4;
   localparam int unsigned ST_CLR   = 3;
   localparam int unsigned ST_EMPTY = 2;
   localparam int unsigned ST_RXERR = 1;
   localparam int unsigned ST_TXERR = 0;

   localparam logic [3:0] ADDR_STATUS = 4'd5;
   localparam int unsigned MODE_EN_BIT = 1;

   typedef struct packed {
      logic push_ok;
      logic pop_ok;
      logic push_miss;
      logic pop_miss;
   } fifo_evt_t;
endpackage

// File: rtl/fifo_store.sv
module fifo_store
   import fifo_stat_pkg::*;
#(
   parameter int unsigned DEPTH = 4096,
   parameter int unsigned DW    = 8,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          clr,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] rdata,
   output logic [CW-1:0] count,
   output fifo_evt_t     evt
);
   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic          is_full, is_empty, act;

   initial begin
      if (DEPTH < 2) $error("fifo_store: DEPTH must be at least 2");
      if (DW < 1) $error("fifo_store: DW must be positive");
   end

   assign is_full  = (count == CW'(DEPTH));
   assign is_empty = (count == '0);
   assign act      = en && !clr;

   always_comb begin
      evt.pop_ok    = act && pop && !is_empty;
      evt.push_ok   = act && push && (!is_full || evt.pop_ok);
      evt.pop_miss  = act && pop && is_empty;
      evt.push_miss = act && push && !evt.push_ok;
   end

   generate
      if (DEPTH == (1 << AW)) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (evt.push_ok) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         rdata  <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (evt.push_ok) wr_ptr <= wr_nxt;
         if (evt.pop_ok) begin
            rd_ptr <= rd_nxt;
            rdata  <= mem[rd_ptr];
         end else if (evt.pop_miss) begin
            rdata  <= '0;
         end
         case ({evt.push_ok, evt.pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R4
   count_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   // R8
   clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count == '0));
   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !clr) |=> ($stable(count) && $stable(rdata)));
   // R6
   under_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr && pop && count == '0) |=> (rdata == '0));
endmodule

// File: rtl/fifo_status_ctl.sv
module fifo_status_ctl
   import fifo_stat_pkg::*;
#(
   parameter int unsigned AWR = 4,
   parameter int unsigned RDW = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           reg_we,
   input  logic [AWR-1:0] reg_addr,
   input  logic [RDW-1:0] reg_wdata,
   input  logic           push_tx,
   input  fifo_evt_t      evt,
   input  logic           empty,
   input  logic           frame_end,
   input  logic           rx_err,
   input  logic           tx_err,
   output logic           clr,
   output logic [7:0]     status
);
   logic ovf_q, udf_q, dir_q;

   initial begin
      if (AWR < 4) $error("fifo_status_ctl: address too narrow");
      if (RDW <= ST_CLR) $error("fifo_status_ctl: data too narrow");
   end

   assign clr = reg_we && (reg_addr == AWR'(ADDR_STATUS)) && reg_wdata[ST_CLR];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q <= 1'b0;
         udf_q <= 1'b0;
         dir_q <= 1'b0;
      end else begin
         if (clr) begin
            ovf_q <= 1'b0;
            udf_q <= 1'b0;
         end else begin
            if (evt.push_miss) ovf_q <= 1'b1;
            if (evt.pop_miss)  udf_q <= 1'b1;
         end
         if (evt.push_ok) dir_q <= push_tx;
      end
   end

   always_comb begin
      status           = '0;
      status[ST_EOF]   = frame_end;
      status[ST_UNDER] = udf_q;
      status[ST_OVER]  = ovf_q;
      status[ST_DIR]   = dir_q;
      status[ST_CLR]   = 1'b0;
      status[ST_EMPTY] = empty;
      status[ST_RXERR] = rx_err;
      status[ST_TXERR] = tx_err;
   end

   // R5
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !clr) |=> ovf_q);
   // R6
   udf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (udf_q && !clr) |=> udf_q);
   // R8
   clr_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!ovf_q && !udf_q));
   // R7
   dir_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt.push_ok |=> (dir_q == $past(push_tx)));
endmodule

// File: rtl/fifo_stat_top.sv
module fifo_stat_top
   import fifo_stat_pkg::*;
#(
   parameter int unsigned DEPTH = 4096,
   localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] mode_bits,
   input  logic       push,
   input  logic       push_tx,
   input  logic [7:0] push_data,
   input  logic       pop,
   output logic [7:0] pop_data,
   input  logic       reg_we,
   input  logic [3:0] reg_addr,
   input  logic [7:0] reg_wdata,
   input  logic       frame_end,
   input  logic       rx_err,
   input  logic       tx_err,
   output logic [7:0] status,
   output logic [7:0] count_lo,
   output logic [7:0] count_hi
);
   logic [CW-1:0] count;
   logic [15:0]   count16;
   logic          clr;
   fifo_evt_t     evt;

   initial begin
      if (CW > 16) $error("fifo_stat_top: count exceeds two bytes");
   end

   fifo_store #(.DEPTH(DEPTH), .DW(8)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (mode_bits[MODE_EN_BIT]),
      .clr   (clr),
      .push  (push),
      .wdata (push_data),
      .pop   (pop),
      .rdata (pop_data),
      .count (count),
      .evt   (evt)
   );

   fifo_status_ctl #(.AWR(4), .RDW(8)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .push_tx   (push_tx),
      .evt       (evt),
      .empty     (count == '0),
      .frame_end (frame_end),
      .rx_err    (rx_err),
      .tx_err    (tx_err),
      .clr       (clr),
      .status    (status)
   );

   assign count16  = 16'(count);
   assign count_lo = count16[7:0];
   assign count_hi = count16[15:8];

   // R9
   always_comb clr_reads_zero_chk: assert (status[ST_CLR] == 1'b0);
   // R5
   ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_bits[MODE_EN_BIT] && !clr && push && !pop && count == CW'(DEPTH))
      |=> (status[ST_OVER] && $stable(count)));
endmodule

// File: tb/tb_fifo_stat_top.sv
module tb_fifo_stat_top;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 4096;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0] mode_bits = 8'h00;
   logic push = 0, push_tx = 0, pop = 0, reg_we = 0;
   logic [7:0] push_data = 0, reg_wdata = 0;
   logic [3:0] reg_addr = 0;
   logic frame_end = 0, rx_err = 0, tx_err = 0;
   logic [7:0] pop_data, status, count_lo, count_hi;

   int checks = 0;
   int fails = 0;
   bit done = 0;
   logic [7:0] model [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   fifo_stat_top dut (
      .clk(clk), .rst_n(rst_n), .mode_bits(mode_bits),
      .push(push), .push_tx(push_tx), .push_data(push_data),
      .pop(pop), .pop_data(pop_data),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .frame_end(frame_end), .rx_err(rx_err), .tx_err(tx_err),
      .status(status), .count_lo(count_lo), .count_hi(count_hi)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one rising edge passes; outputs are read afterwards at the falling edge
   task automatic step();
      @(negedge clk);
   endtask

   task automatic idle();
      push = 0; pop = 0; reg_we = 0;
   endtask

   task automatic do_push(input logic [7:0] d, input logic tx);
      push = 1; push_tx = tx; push_data = d; step(); idle();
   endtask

   task automatic do_pop();
      pop = 1; step(); idle();
   endtask

   task automatic do_clear();
      reg_we = 1; reg_addr = 4'd5; reg_wdata = 8'h08; step(); idle();
      model.delete();
   endtask

   task automatic t_reset();
      chk("R1 count_lo", {8'h0, count_lo}, 16'h0);
      chk("R1 count_hi", {8'h0, count_hi}, 16'h0);
      chk("R1 pop_data", {8'h0, pop_data}, 16'h0);
      chk("R1 status", {8'h0, status}, 16'h0004);
   endtask

   task automatic t_order();
      mode_bits = 8'h02;
      for (int i = 0; i < 5; i++) begin
         do_push(8'hA0 + 8'(i), 1'b0);
         model.push_back(8'hA0 + 8'(i));
      end
      chk("R4 count 5", {count_hi, count_lo}, 16'd5);
      chk("R10 not empty", {15'h0, status[2]}, 16'h0);
      for (int i = 0; i < 5; i++) begin
         do_pop();
         chk("R2 order", {8'h0, pop_data}, {8'h0, model.pop_front()});
      end
      chk("R10 empty", {15'h0, status[2]}, 16'h1);
      chk("R6 no underflow yet", {15'h0, status[6]}, 16'h0);
   endtask

   task automatic t_dir();
      do_push(8'h11, 1'b1); model.push_back(8'h11);
      chk("R7 tx dir", {15'h0, status[4]}, 16'h1);
      do_push(8'h22, 1'b0); model.push_back(8'h22);
      chk("R7 rx dir", {15'h0, status[4]}, 16'h0);
      do_clear();
      chk("R8 cleared count", {count_hi, count_lo}, 16'h0);
   endtask

   task automatic t_disabled();
      do_push(8'h5A, 1'b0); model.push_back(8'h5A);
      do_pop(); void'(model.pop_front());
      chk("R2 setup", {8'h0, pop_data}, 16'h005A);
      mode_bits = 8'hFD;
      do_push(8'h77, 1'b1);
      chk("R3 count held", {count_hi, count_lo}, 16'h0);
      chk("R3 dir held", {15'h0, status[4]}, 16'h0);
      do_pop();
      chk("R3 pop_data held", {8'h0, pop_data}, 16'h005A);
      chk("R3 no underflow", {15'h0, status[6]}, 16'h0);
      mode_bits = 8'h02;
   endtask

   task automatic t_underflow();
      do_pop();
      chk("R6 zero data", {8'h0, pop_data}, 16'h0);
      chk("R6 flag", {15'h0, status[6]}, 16'h1);
      do_push(8'h33, 1'b0);
      do_pop();
      chk("R6 sticky", {15'h0, status[6]}, 16'h1);
      chk("R9 clr bit", {15'h0, status[3]}, 16'h0);
      // other address / missing bit: no effect
      reg_we = 1; reg_addr = 4'd4; reg_wdata = 8'h08; step(); idle();
      chk("R8 wrong addr", {15'h0, status[6]}, 16'h1);
      reg_we = 1; reg_addr = 4'd5; reg_wdata = 8'hF7; step(); idle();
      chk("R8 no clr bit", {15'h0, status[6]}, 16'h1);
      do_clear();
      chk("R8 flag cleared", {15'h0, status[6]}, 16'h0);
   endtask

   task automatic t_fill();
      for (int i = 0; i < DEPTH; i++) begin
         do_push(8'(i * 7 + 3), 1'b1);
         model.push_back(8'(i * 7 + 3));
      end
      chk("R4 full lo", {8'h0, count_lo}, 16'h0);
      chk("R4 full hi", {8'h0, count_hi}, 16'h0010);
      do_push(8'hEE, 1'b0);
      chk("R5 overflow", {15'h0, status[5]}, 16'h1);
      chk("R5 count kept", {count_hi, count_lo}, 16'd4096);
      chk("R7 dropped push keeps dir", {15'h0, status[4]}, 16'h1);
      push = 1; pop = 1; push_data = 8'hC4; push_tx = 1; step(); idle();
      model.push_back(8'hC4);
      chk("R12 full both count", {count_hi, count_lo}, 16'd4096);
      chk("R12 full both data", {8'h0, pop_data}, {8'h0, model.pop_front()});
      for (int i = 0; i < DEPTH; i++) begin
         do_pop();
         if (pop_data !== model[0])
            chk("R2 long order", {8'h0, pop_data}, {8'h0, model[0]});
         void'(model.pop_front());
      end
      checks++;
      chk("R5 still set", {15'h0, status[5]}, 16'h1);
      chk("R10 empty after drain", {15'h0, status[2]}, 16'h1);
      do_push(8'h99, 1'b0);
      // clear together with a push: push ignored
      reg_we = 1; reg_addr = 4'd5; reg_wdata = 8'h08; push = 1; push_data = 8'h44;
      step(); idle(); model.delete();
      chk("R8 clear wins", {count_hi, count_lo}, 16'h0);
      chk("R8 ovf cleared", {15'h0, status[5]}, 16'h0);
   endtask

   task automatic t_simul_empty();
      push = 1; pop = 1; push_data = 8'h61; push_tx = 0; step(); idle();
      chk("R12 empty both count", {count_hi, count_lo}, 16'd1);
      chk("R12 empty both data", {8'h0, pop_data}, 16'h0);
      chk("R12 empty both underflow", {15'h0, status[6]}, 16'h1);
      do_pop();
      chk("R12 byte kept", {8'h0, pop_data}, 16'h0061);
   endtask

   task automatic t_events();
      frame_end = 1; #1;
      chk("R11 eof", {8'h0, status & 8'h83}, 16'h0080);
      frame_end = 0; rx_err = 1; #1;
      chk("R11 rx", {8'h0, status & 8'h83}, 16'h0002);
      rx_err = 0; tx_err = 1; #1;
      chk("R11 tx", {8'h0, status & 8'h83}, 16'h0001);
      tx_err = 0; #1;
      chk("R11 none", {8'h0, status & 8'h83}, 16'h0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual running expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      step(); step();
      t_reset();
      rst_n = 1;
      step();
      t_reset();
      t_order();
      t_dir();
      t_disabled();
      t_underflow();
      t_fill();
      t_simul_empty();
      t_events();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule